// File: doc/BRIEF.md
# Dual-Reload Pulse Timer

This block turns a count-enable tick into a repeating two-phase pulse train. A first phase, of a length held in one reload register, drives the output to its active level. A second phase, of a length held in another reload register, drives it to its idle level. The two phases then alternate until software stops the timer. Counting is armed by a start bit and begins only on a rising edge of an external trigger. Once the train is running, further trigger edges are ignored.

Reload values are written into shadow registers at any time. A new value is picked up only when the counter next loads the phase it belongs to, so a phase that has already begun always runs to its old length. A polarity bit selects whether the idle level is low or high. A sticky interrupt flag records each transition of the output from active to idle. It is cleared by an acknowledge pulse or by a software write.

Top module: `dual_pulse_timer`

## Requirements
- R1: After reset the output is low, the interrupt flag is 0 and the timer is stopped.
- R2: Once running, the output holds its active level for max(A,1) tick-enabled cycles and then its idle level for max(B,1) tick-enabled cycles, and this pair repeats. A is the value written at address 0 and B is the value written at address 1.
- R3: Counting starts only on a rising edge of `trigIn` (low in one cycle, high in the next) while the start bit (bit 0 of the control word at address 2) is 1. A trigger that is already high when the start bit is set does not start the timer, and edges while the start bit is 0 are ignored.
- R4: Trigger edges that arrive while the timer is running do not restart or alter the pulse train.
- R5: With the polarity bit (bit 1 of the control word) at 0, the idle level is low and the active level is high. With it at 1, both levels are inverted.
- R6: Writing the control word with bit 0 cleared stops the timer, and the output shows the idle level from the next cycle.
- R7: The interrupt flag is set in the cycle the output goes from its active level to its idle level, whether at a phase change or at a stop. Entering the active phase does not set it.
- R8: The interrupt flag stays set until an `intAck` pulse or a control write with bit 2 set clears it. If a clear and a new active-to-idle transition fall in the same cycle, the flag ends up set.
- R9: A reload write made during a phase leaves that phase's length unchanged. A write that lands in the same cycle as the load of its phase is used only from the following load of that phase.
- R10: A reload value of 0 gives a phase that lasts one tick.
- R11: The counter advances only in cycles where `tick` is 1. Without ticks, the output holds its current phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 reload A, 1 reload B, 2 control, 3 unused |
| wrData | input | CNT_W | Write data; control uses bit 0 start, bit 1 polarity, bit 2 clear flag |
| tick | input | 1 | Count-source enable |
| trigIn | input | 1 | External start trigger |
| intAck | input | 1 | Interrupt acknowledge pulse, clears the flag |
| pulseOut | output | 1 | Pulse train output |
| irqFlag | output | 1 | Sticky interrupt request flag |

## Verification
Two collisions are provoked on purpose. In the first, the clearing of the interrupt flag meets its setting. For every reload pair and both polarities, the bench pulses `intAck` on the edge that ends the active phase. It expects the flag to read 1 after that edge and 0 after a second acknowledge one cycle later. In the second, a reload write lands on the very edge that loads its phase. The bench expects the old length for that phase and the new length only on the following load of the same phase.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int ADDR_W = 2;
  localparam int NUM_PH = 2;

  localparam logic [ADDR_W-1:0] REG_RELOAD_A = 2'd0;
  localparam logic [ADDR_W-1:0] REG_RELOAD_B = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CTRL     = 2'd2;

  localparam int CTRL_START = 0;
  localparam int CTRL_POL   = 1;
  localparam int CTRL_CLR   = 2;
  localparam int CTRL_W     = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } runState_e;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic dec;
  } cntStrobe_t;
endpackage

// File: rtl/dpt_datapath.sv
module dpt_datapath
  import dpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  cntStrobe_t        strobe,
  output logic              cntLast,
  output logic [CNT_W-1:0]  cntValue
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_PH-1:0][CNT_W-1:0] shadowVal;
  logic [CNT_W-1:0]             cnt;

  // one shadow register per phase; its address equals its phase index
  for (genvar g = 0; g < NUM_PH; g++) begin : g_shadow
    logic [CNT_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
        val <= wrData;
      end
    end
    assign shadowVal[g] = val;
  end

  // the counter copies a shadow value at the edge that opens a phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadA) begin
      cnt <= shadowVal[0];
    end else if (strobe.loadB) begin
      cnt <= shadowVal[1];
    end else if (strobe.dec) begin
      cnt <= cnt - ONE;
    end
  end

  // zero or one left: this tick closes the phase (zero counts as one tick)
  assign cntLast  = (cnt <= ONE);
  assign cntValue = cnt;
endmodule

// File: rtl/dpt_control.sv
module dpt_control
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrCtrl,
  input  logic              tick,
  input  logic              trigIn,
  input  logic              intAck,
  input  logic              cntLast,
  output cntStrobe_t        strobe,
  output logic              activeLvl,
  output logic              polBit,
  output logic              irqFlag,
  output runState_e         runState
);
  logic      startBit;
  logic      trigPrev;
  logic      ctrlWr;
  logic      startNext;
  logic      trigRise;
  logic      actNext;
  logic      fallEv;
  logic      clrReq;
  runState_e stateNext;

  assign ctrlWr    = wrEn && (wrAddr == REG_CTRL);
  assign startNext = ctrlWr ? wrCtrl[CTRL_START] : startBit;
  assign trigRise  = trigIn && !trigPrev;

  always_comb begin
    strobe    = '0;
    stateNext = runState;
    actNext   = activeLvl;
    unique case (runState)
      ST_IDLE: begin
        if (startNext) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (!startNext) begin
          stateNext = ST_IDLE;
        end else if (trigRise) begin
          stateNext    = ST_RUN;
          strobe.loadA = 1'b1;
          actNext      = 1'b1;
        end
      end
      ST_RUN: begin
        // trigger is not looked at here: no retrigger
        if (!startNext) begin
          stateNext = ST_IDLE;
          actNext   = 1'b0;
        end else if (tick) begin
          if (cntLast) begin
            actNext = !activeLvl;
            if (activeLvl) strobe.loadB = 1'b1;
            else           strobe.loadA = 1'b1;
          end else begin
            strobe.dec = 1'b1;
          end
        end
      end
      default: begin
        stateNext = ST_IDLE;
        actNext   = 1'b0;
      end
    endcase
  end

  assign fallEv = activeLvl && !actNext;
  assign clrReq = intAck || (ctrlWr && wrCtrl[CTRL_CLR]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runState  <= ST_IDLE;
      activeLvl <= 1'b0;
      startBit  <= 1'b0;
      polBit    <= 1'b0;
      trigPrev  <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      runState  <= stateNext;
      activeLvl <= actNext;
      startBit  <= startNext;
      trigPrev  <= trigIn;
      if (ctrlWr) polBit <= wrCtrl[CTRL_POL];
      // a new event outranks a clear in the same cycle
      if (fallEv)      irqFlag <= 1'b1;
      else if (clrReq) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_pulse_timer.sv
module dual_pulse_timer
  import dpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tick,
  input  logic              trigIn,
  input  logic              intAck,
  output logic              pulseOut,
  output logic              irqFlag
);
  cntStrobe_t       strobe;
  logic             cntLast;
  logic [CNT_W-1:0] cntValue;
  logic             activeLvl;
  logic             polBit;
  runState_e        runState;

  dpt_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrCtrl   (wrData[CTRL_W-1:0]),
    .tick     (tick),
    .trigIn   (trigIn),
    .intAck   (intAck),
    .cntLast  (cntLast),
    .strobe   (strobe),
    .activeLvl(activeLvl),
    .polBit   (polBit),
    .irqFlag  (irqFlag),
    .runState (runState)
  );

  dpt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .cntLast (cntLast),
    .cntValue(cntValue)
  );

  assign pulseOut = polBit ^ activeLvl;
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker
  import dpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [CNT_W-1:0]  wrData,
  input logic              tick,
  input logic              intAck,
  input logic              pulseOut,
  input logic              irqFlag,
  input logic              activeLvl,
  input logic              polBit,
  input logic [CNT_W-1:0]  cntValue,
  input runState_e         runState
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == REG_CTRL);

  // R5: outside the running state the output sits at the idle level
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runState != ST_RUN) |-> (pulseOut == polBit));

  // R6: a stop write leaves the timer stopped with the output inactive
  p_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[CTRL_START]) |=> (runState == ST_IDLE && !activeLvl));

  // R7: every active-to-idle transition leaves the flag set
  p_irq_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeLvl) |-> irqFlag);

  // R7: the flag never rises without such a transition
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $fell(activeLvl));

  // R8: without a clear request the flag stays set
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !intAck && !(ctrlWr && wrData[CTRL_CLR])) |=> irqFlag);

  // R11: no tick, no count change while running
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (runState == ST_RUN && !tick) |=> $stable(cntValue));
endmodule

bind dual_pulse_timer dpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .tick     (tick),
  .intAck   (intAck),
  .pulseOut (pulseOut),
  .irqFlag  (irqFlag),
  .activeLvl(activeLvl),
  .polBit   (polBit),
  .cntValue (cntValue),
  .runState (runState)
);

// File: tb/dual_pulse_timer_tb.sv
`timescale 1ns/1ps
module dual_pulse_timer_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic          tick = 1'b0;
  logic          trigIn = 1'b0;
  logic          intAck = 1'b0;
  logic          pulseOut;
  logic          irqFlag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_pulse_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tick(tick), .trigIn(trigIn), .intAck(intAck),
    .pulseOut(pulseOut), .irqFlag(irqFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = CW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic armTimer(input int pol, input int ra, input int rb);
    writeReg(2, pol << 1);            // stop
    writeReg(2, 4 | (pol << 1));      // clear flag
    writeReg(0, ra);
    writeReg(1, rb);
    writeReg(2, 4 | (pol << 1) | 1);  // start, armed
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 output", pulseOut, 0);
    chk("R1 flag", irqFlag, 0);

    // R3: edge while stopped is ignored
    writeReg(0, 3);
    writeReg(1, 2);
    trigIn = 1'b1;
    @(negedge clk); trigIn = 1'b0;
    @(negedge clk);
    chk("R3 edge while stopped", pulseOut, 0);
    // R3: trigger already high when start is set does not start
    trigIn = 1'b1;
    writeReg(2, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R3 high level no start", pulseOut, 0);
    trigIn = 1'b0;
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk);
    chk("R3 rising edge starts", pulseOut, 1);
    // R11: no ticks, phase held
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R11 held without tick", pulseOut, 1);
    end
    tick = 1'b1;
    @(negedge clk); chk("R11 tick 1", pulseOut, 1);
    @(negedge clk); chk("R11 tick 2", pulseOut, 1);
    @(negedge clk); chk("R11 tick 3 ends phase", pulseOut, 0);
    tick = 1'b0;
    trigIn = 1'b0;

    // R6 / R7 / R8: stop during the active phase
    armTimer(0, 3, 3);
    @(negedge clk); trigIn = 1'b1;
    @(negedge clk);
    chk("R6 running active", pulseOut, 1);
    chk("R7 no flag on entering active", irqFlag, 0);
    writeReg(2, 0);
    chk("R6 idle after stop", pulseOut, 0);
    chk("R7 flag on stop fall", irqFlag, 1);
    @(negedge clk);
    chk("R8 flag sticky", irqFlag, 1);
    writeReg(2, 4);
    chk("R8 software clear", irqFlag, 0);
    writeReg(2, 2);
    chk("R5 idle high with polarity 1", pulseOut, 1);
    trigIn = 1'b0;

    // R2/R4/R5/R7/R8/R10 sweep
    tick = 1'b1;
    for (int pol = 0; pol < 2; pol++) begin
      for (int m = 0; m < 5; m++) begin
        for (int n = 0; n < 5; n++) begin
          int ma;
          int nb;
          int per;
          ma  = (m == 0) ? 1 : m;   // R10
          nb  = (n == 0) ? 1 : n;
          per = ma + nb;
          trigIn = 1'b0;
          armTimer(pol, m, n);
          chk("R5 armed idle level", pulseOut, pol);
          chk("R8 flag cleared", irqFlag, 0);
          trigIn = 1'b1;
          for (int s = 0; s < 2 * per; s++) begin
            int act;
            @(negedge clk);
            act = ((s % per) < ma) ? 1 : 0;
            chk("R2 R4 R5 R10 waveform", pulseOut, pol ^ act);
            if (s == ma - 1) chk("R7 no flag during active", irqFlag, 0);
            if (s == ma)     chk("R8 set wins over ack", irqFlag, 1);
            if (s == ma + 1) chk("R8 ack clears", irqFlag, 0);
            intAck = (s == ma - 1) || (s == ma);
            trigIn = s[1];   // R4: toggling trigger while running
          end
          intAck = 1'b0;
        end
      end
    end
    trigIn = 1'b0;

    // R9: reload writes mid-phase and on the load edge
    armTimer(0, 4, 4);
    trigIn = 1'b1;
    for (int s = 0; s < 14; s++) begin
      int act;
      @(negedge clk);
      act = ((s < 4) || (s >= 8 && s <= 9) || (s >= 11 && s <= 12)) ? 1 : 0;
      chk("R9 shadow reload", pulseOut, act);
      wrEn = 1'b0;
      if (s == 1) begin wrEn = 1'b1; wrAddr = 2'd0; wrData = CW'(2); end
      if (s == 3) begin wrEn = 1'b1; wrAddr = 2'd1; wrData = CW'(1); end
    end
    wrEn = 1'b0;
    writeReg(2, 0);
    chk("R6 final stop", pulseOut, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule